// File: doc/BRIEF.md
# Interleaved Multiphase PWM Generator

This block drives the gates of a multiphase buck converter. It produces up to four complementary pairs of high-side and low-side signals. A single counter runs through one switching period, and each phase reads that counter at its own fixed offset. With phase shifting on, the phase edges are spread evenly over the period. One input selects the carrier shape: a triangle gives modulation on both edges, and a sawtooth gives modulation on one edge. The period and the modulation word are each 12 bits and are counted in clock cycles.

Every phase compares the same modulation word against its own view of the carrier. In triangle mode a programmable dead time holds off the turn-on of each switch, so the two switches of a leg are never on together. The block also drives two outputs for sampling logic: a bus that carries the position of the phase 0 carrier, and a strobe that is high for one cycle at the start of every period.

The period, modulation word, shape, phase count and shift enable are loaded into shadow registers only on the last cycle of a period. A change in the middle of a period therefore cannot cut a pulse short.

Top module: `mpwm_interleave`

## Requirements
- R1: While the reset is held, every gate output is low, the carrier bus reads 0 and the strobe is high, whatever the value of the output enable.
- R2: In sawtooth mode (shape input low), one period lasts P+1 clocks for a period word P ≥ 1. The carrier runs 0..P and then wraps to 0. The high-side switch of a phase is on for D clocks per period, where D is the modulation word and D < P.
- R3: In triangle mode (shape input high), one period lasts 2P clocks. The carrier climbs from 0 to P and comes back down. Without dead time, the high-side switch is on for 2D−1 clocks per period when 1 ≤ D < P, and the low-side switch is on for the rest of the period.
- R4: A modulation word of 0 keeps the high-side switch off for the whole period. A word at or above P keeps the high-side switch on and the low-side switch off.
- R5: In triangle mode, each turn-on of either switch is delayed by the dead-time word in clocks, so each on-interval is that many clocks shorter. The two switches of a leg are never high together.
- R6: In sawtooth mode the dead-time word has no effect on the gate outputs.
- R7: With phase shift enabled, phase k runs ahead of phase 0 by floor(k·L/n) clocks. Here L is the period length in clocks and n is the active phase count. Measured from a rising edge of the phase 0 high-side switch, the next rising edge of phase k comes L − floor(k·L/n) clocks later.
- R8: With phase shift disabled, all active phases switch in the same cycle.
- R9: The 3-bit phase-count input selects n active phases. A value of 0 is treated as 1, and any value above 4 is treated as 4. The phases at index n and above keep both switches off.
- R10: When the output enable is low, all gate outputs are low in the same cycle.
- R11: The strobe is high for exactly one cycle per period, on the cycle where the carrier is at position 0. The shadowed settings change only in that cycle. A new period word written in the middle of a period takes effect only after the current period has finished.
- R12: The carrier bus shows the carrier value of phase 0 and never goes above the active period word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low, released synchronously inside the block |
| period_i | input | 12 | Carrier period word P |
| duty_i | input | 12 | Modulation word D |
| dtime_i | input | 7 | Dead time in clocks (triangle mode only) |
| nph_i | input | 3 | Requested number of active phases |
| tri_sel_i | input | 1 | 1 = triangle carrier, 0 = sawtooth carrier |
| shift_en_i | input | 1 | 1 = spread the phases over the period |
| oe_i | input | 1 | Output enable; low forces all gates off |
| hs_o | output | 4 | High-side gate, one bit per phase |
| ls_o | output | 4 | Low-side gate, one bit per phase |
| carrier_o | output | 12 | Phase 0 carrier position |
| strobe_o | output | 1 | One-cycle pulse at the start of each period |

## Verification
The checker assumes that the dead-time word is held steady while a leg is in its off gap. The shoot-through check depends on this: if the word shrinks in mid-gap, it would release a switch early. The checker also takes the output enable as a plain synchronous level. The bench changes the dead time, shape, phase count and enable only while reconfiguring, and each change is followed by several full periods of settling before anything is measured. All periods used are nonzero and at most 100 clocks, so every measured window covers whole periods.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int unsigned CNT_W   = 12;             // period / modulation width
  localparam int unsigned LEN_W   = CNT_W + 1;      // period length in clocks
  localparam int unsigned DT_W    = 7;              // dead-time width
  localparam int unsigned PHC_W   = 3;              // phase-count field width
  localparam int unsigned OFF_W   = LEN_W + PHC_W;  // product k * length

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [LEN_W-1:0] len_t;

  typedef struct packed {
    cnt_t             per;
    cnt_t             duty;
    logic             tri_m;
    logic             shift;
    logic [PHC_W-1:0] nact;
  } shadow_t;

  // clocks in one carrier period
  function automatic len_t seq_len(input shadow_t s);
    if (s.per == '0) return len_t'(1);
    if (s.tri_m)     return {s.per, 1'b0};
    return len_t'(s.per) + len_t'(1);
  endfunction

  // carrier value seen at sequence position p
  function automatic cnt_t carrier_at(input shadow_t s, input len_t p);
    len_t down;
    down = {s.per, 1'b0} - p;
    if (s.tri_m && (p > len_t'(s.per))) return down[CNT_W-1:0];
    return p[CNT_W-1:0];
  endfunction

  // lead of phase k over phase 0, in clocks
  function automatic len_t phase_off(input int unsigned k, input len_t len,
                                     input logic [PHC_W-1:0] nact, input logic shift);
    logic [OFF_W-1:0] prod;
    if (!shift || (k == 0) || (nact == '0)) return '0;
    prod = OFF_W'(k) * OFF_W'(len);
    return len_t'(prod / OFF_W'(nact));
  endfunction
endpackage

// File: rtl/mpwm_carrier.sv
module mpwm_carrier
  import mpwm_pkg::*;
#(
  parameter int unsigned NPH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_t             period_i,
  input  cnt_t             duty_i,
  input  logic [PHC_W-1:0] nph_i,
  input  logic             tri_sel_i,
  input  logic             shift_en_i,
  output shadow_t          sh_o,
  output len_t             pos_o,
  output len_t             len_o,
  output logic             live_o,
  output logic             strobe_o
);
  shadow_t          sh_q, sh_d;
  len_t             pos_q, pos_d, len;
  logic             live_q, last, sh_en;
  logic [PHC_W-1:0] nact_c;

  // next-state
  always_comb begin
    nact_c = nph_i;
    if (nph_i == '0)                nact_c = PHC_W'(1);
    else if (nph_i > PHC_W'(NPH))   nact_c = PHC_W'(NPH);
    len   = seq_len(sh_q);
    last  = (pos_q == (len - len_t'(1)));
    sh_en = last;
    pos_d = last ? '0 : (pos_q + len_t'(1));
    sh_d  = '{per: period_i, duty: duty_i, tri_m: tri_sel_i,
              shift: shift_en_i, nact: nact_c};
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '{per: '0, duty: '0, tri_m: 1'b0, shift: 1'b0, nact: PHC_W'(1)};
      pos_q  <= '0;
      live_q <= 1'b0;
    end else begin
      if (sh_en) sh_q <= sh_d;
      pos_q  <= pos_d;
      live_q <= 1'b1;
    end
  end

  assign sh_o     = sh_q;
  assign pos_o    = pos_q;
  assign len_o    = len;
  assign live_o   = live_q;
  assign strobe_o = (pos_q == '0);
endmodule

// File: rtl/mpwm_leg.sv
module mpwm_leg
  import mpwm_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  shadow_t         sh_i,
  input  len_t            pos_i,
  input  len_t            len_i,
  input  len_t            off_i,
  input  logic [DT_W-1:0] dtime_i,
  input  logic            live_i,
  input  logic            oe_i,
  output logic            hs_o,
  output logic            ls_o
);
  logic [LEN_W:0]  sum;
  len_t            ph_pos;
  cnt_t            car;
  logic            raw_d, raw_q, active, settled;
  logic [DT_W-1:0] run_d, run_q, dt_eff;

  // next-state: phase position, compare, gap counter
  always_comb begin
    sum    = {1'b0, pos_i} + {1'b0, off_i};
    ph_pos = (sum >= {1'b0, len_i}) ? len_t'(sum - {1'b0, len_i}) : sum[LEN_W-1:0];
    car    = carrier_at(sh_i, ph_pos);
    raw_d  = (sh_i.duty >= sh_i.per) ? 1'b1 : (car < sh_i.duty);
    run_d  = run_q;
    if (raw_d != raw_q)     run_d = '0;
    else if (run_q != '1)   run_d = run_q + 1'b1;
    dt_eff  = sh_i.tri_m ? dtime_i : '0;
    active  = (PHC_W'(IDX) < sh_i.nact);
    settled = (run_q >= dt_eff);
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      run_q <= '0;
    end else begin
      raw_q <= raw_d;
      run_q <= run_d;
    end
  end

  assign hs_o = live_i & oe_i & active &  raw_q & settled;
  assign ls_o = live_i & oe_i & active & ~raw_q & settled;
endmodule

// File: rtl/mpwm_interleave.sv
module mpwm_interleave
  import mpwm_pkg::*;
#(
  parameter int unsigned NPH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dtime_i,
  input  logic [PHC_W-1:0] nph_i,
  input  logic             tri_sel_i,
  input  logic             shift_en_i,
  input  logic             oe_i,
  output logic [NPH-1:0]   hs_o,
  output logic [NPH-1:0]   ls_o,
  output logic [CNT_W-1:0] carrier_o,
  output logic             strobe_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n, live;
  shadow_t    sh;
  len_t       pos, len;
  len_t       offs [NPH];

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  mpwm_carrier #(.NPH(NPH)) carrier_i (
    .clk_i(clk_i), .rst_ni(rst_n), .period_i(period_i), .duty_i(duty_i),
    .nph_i(nph_i), .tri_sel_i(tri_sel_i), .shift_en_i(shift_en_i),
    .sh_o(sh), .pos_o(pos), .len_o(len), .live_o(live), .strobe_o(strobe_o)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_leg
    assign offs[k] = phase_off(k, len, sh.nact, sh.shift);
    mpwm_leg #(.IDX(k)) leg_i (
      .clk_i(clk_i), .rst_ni(rst_n), .sh_i(sh), .pos_i(pos), .len_i(len),
      .off_i(offs[k]), .dtime_i(dtime_i), .live_i(live), .oe_i(oe_i),
      .hs_o(hs_o[k]), .ls_o(ls_o[k])
    );
  end

  assign carrier_o = carrier_at(sh, pos);
endmodule

// File: rtl/mpwm_interleave_chk.sv
module mpwm_interleave_chk
  import mpwm_pkg::*;
#(
  parameter int unsigned NPH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             oe_i,
  input logic [NPH-1:0]   hs_i,
  input logic [NPH-1:0]   ls_i,
  input logic             strobe_i,
  input logic [CNT_W-1:0] carrier_i,
  input shadow_t          sh_i,
  input len_t             len_i
);
  // R5
  no_shoot_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_i & ls_i) == '0);

  // R10
  oe_gates_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> ((hs_i | ls_i) == '0));

  // R11
  shadow_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sh_i) |-> strobe_i);

  // R11
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && (len_i > len_t'(1))) |=> !strobe_i);

  // R12
  carrier_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carrier_i <= sh_i.per);

  for (genvar k = 0; k < NPH; k++) begin : g_unused
    // R9
    unused_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (PHC_W'(k) >= sh_i.nact) |-> (!hs_i[k] && !ls_i[k]));
  end
endmodule

bind mpwm_interleave mpwm_interleave_chk #(.NPH(NPH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_n), .oe_i(oe_i), .hs_i(hs_o), .ls_i(ls_o),
  .strobe_i(strobe_o), .carrier_i(carrier_o), .sh_i(sh), .len_i(len)
);

// File: tb/mpwm_interleave_tb.sv
`timescale 1ns/1ps
module mpwm_interleave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] period, duty;
  logic [6:0]  dtime;
  logic [2:0]  nph;
  logic        tri_sel, shift_en, oe;
  logic [3:0]  hs, ls;
  logic [11:0] carrier;
  logic        strobe;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  mpwm_interleave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .period_i(period), .duty_i(duty), .dtime_i(dtime),
    .nph_i(nph), .tri_sel_i(tri_sel), .shift_en_i(shift_en), .oe_i(oe),
    .hs_o(hs), .ls_o(ls), .carrier_o(carrier), .strobe_o(strobe)
  );

  typedef struct { string tag; int kind; int ph; int win; int ex; } item_t;
  item_t exp_q[$];

  task automatic check(input string tag, input int act, input int ex);
    n_chk++;
    if (act != ex) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, ex);
    end
  endtask

  // kinds: 0 hs-on count, 1 ls-on count, 2 rise delay from phase 0,
  //        3 strobe count, 4 any-gate-on count, 5 carrier maximum
  task automatic expect_it(input string tag, input int kind, input int ph,
                           input int win, input int ex);
    item_t it;
    it.tag = tag; it.kind = kind; it.ph = ph; it.win = win; it.ex = ex;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  // expected on-times derived from the requirements
  function automatic int tri_hi(int p, int d, int dt);
    if (d >= p) return 2 * p;
    if (d == 0) return 0;
    return 2 * d - 1 - dt;
  endfunction
  function automatic int tri_lo(int p, int d, int dt);
    if (d >= p) return 0;
    if (d == 0) return 2 * p;
    return 2 * p - (2 * d - 1) - dt;
  endfunction
  function automatic int saw_hi(int p, int d);
    return (d >= p) ? p + 1 : d;
  endfunction
  function automatic int rise_gap(int len, int k, int n, bit sh);
    int off;
    off = sh ? (k * len) / n : 0;
    return (off == 0) ? 0 : len - off;
  endfunction

  // monitor: pops expected items, measures, compares
  initial begin : monitor
    forever begin
      item_t it;
      int    got, c;
      logic  p0, pk;
      wait (exp_q.size() > 0);
      it  = exp_q[0];
      got = 0;
      case (it.kind)
        0: repeat (it.win) begin @(negedge clk); if (hs[it.ph]) got++; end
        1: repeat (it.win) begin @(negedge clk); if (ls[it.ph]) got++; end
        2: begin
          got = -1; c = -1;
          @(negedge clk); p0 = hs[0]; pk = hs[it.ph];
          for (int i = 0; i < it.win && got < 0; i++) begin
            @(negedge clk);
            if (c >= 0) c++;
            if (c < 0 && hs[0] && !p0) c = 0;
            if (c >= 0 && hs[it.ph] && !pk) got = c;
            p0 = hs[0]; pk = hs[it.ph];
          end
        end
        3: repeat (it.win) begin @(negedge clk); if (strobe) got++; end
        4: repeat (it.win) begin @(negedge clk); if (hs[it.ph] || ls[it.ph]) got++; end
        default: repeat (it.win) begin
          @(negedge clk); if (int'(carrier) > got) got = int'(carrier);
        end
      endcase
      check(it.tag, got, it.ex);
      void'(exp_q.pop_front());
    end
  end

  task automatic cfg(input int p, input int d, input int dt, input int n,
                     input bit tr, input bit sh, input bit en);
    @(negedge clk);
    period = 12'(p); duty = 12'(d); dtime = 7'(dt); nph = 3'(n);
    tri_sel = tr; shift_en = sh; oe = en;
    repeat (600) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin : driver
    int c;
    rst_n = 1'b0; period = 12'd99; duty = 12'd30; dtime = 7'd20; nph = 3'd4;
    tri_sel = 1'b0; shift_en = 1'b1; oe = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state with the enable high
    check("R1 gates in reset", int'({hs, ls}), 0);
    check("R1 carrier in reset", int'(carrier), 0);
    check("R1 strobe in reset", int'(strobe), 1);
    rst_n = 1'b1;

    // sawtooth, four phases, dead time set but ignored
    cfg(99, 30, 20, 4, 0, 1, 1);
    for (int k = 0; k < 4; k++) begin
      expect_it($sformatf("R2 R6 saw hs ph%0d", k), 0, k, 100, saw_hi(99, 30));
      expect_it($sformatf("R6 saw ls ph%0d", k), 1, k, 100, 100 - saw_hi(99, 30));
    end
    for (int k = 1; k < 4; k++)
      expect_it($sformatf("R7 saw gap ph%0d", k), 2, k, 300, rise_gap(100, k, 4, 1));
    expect_it("R12 saw carrier max", 5, 0, 100, 99);
    expect_it("R11 saw strobes", 3, 0, 100, 1);
    drain();

    // R11 period change mid-period waits for the end of the period
    do @(negedge clk); while (!strobe);
    repeat (10) @(negedge clk);
    period = 12'd49;
    c = 0;
    do begin @(negedge clk); c++; end while (!strobe);
    check("R11 old period completes", c, 90);
    c = 0;
    do begin @(negedge clk); c++; end while (!strobe);
    check("R11 new period used", c, 50);

    // triangle, no dead time
    cfg(50, 20, 0, 4, 1, 1, 1);
    expect_it("R3 tri hs", 0, 0, 100, tri_hi(50, 20, 0));
    expect_it("R3 tri ls", 1, 0, 100, tri_lo(50, 20, 0));
    expect_it("R3 R12 tri carrier max", 5, 0, 100, 50);
    expect_it("R3 R11 tri strobes", 3, 0, 200, 2);
    drain();

    // triangle with dead time
    cfg(50, 20, 6, 4, 1, 1, 1);
    for (int k = 0; k < 4; k++) begin
      expect_it($sformatf("R5 tri dt hs ph%0d", k), 0, k, 100, tri_hi(50, 20, 6));
      expect_it($sformatf("R5 tri dt ls ph%0d", k), 1, k, 100, tri_lo(50, 20, 6));
    end
    drain();

    // three phases, triangle
    cfg(48, 20, 6, 3, 1, 1, 1);
    expect_it("R7 n3 gap ph1", 2, 1, 300, rise_gap(96, 1, 3, 1));
    expect_it("R7 n3 gap ph2", 2, 2, 300, rise_gap(96, 2, 3, 1));
    expect_it("R5 n3 hs ph2", 0, 2, 96, tri_hi(48, 20, 6));
    expect_it("R9 n3 ph3 off", 4, 3, 96, 0);
    drain();

    // two phases
    cfg(50, 20, 6, 2, 1, 1, 1);
    expect_it("R7 n2 gap ph1", 2, 1, 300, rise_gap(100, 1, 2, 1));
    expect_it("R9 n2 ph2 off", 4, 2, 100, 0);
    expect_it("R9 n2 ph3 off", 4, 3, 100, 0);
    drain();

    // shift disabled
    cfg(50, 20, 6, 4, 1, 0, 1);
    for (int k = 1; k < 4; k++)
      expect_it($sformatf("R8 aligned ph%0d", k), 2, k, 300, 0);
    drain();

    // phase count field 0 and 7
    cfg(50, 20, 6, 0, 1, 1, 1);
    expect_it("R9 count0 ph0 runs", 0, 0, 100, tri_hi(50, 20, 6));
    expect_it("R9 count0 ph1 off", 4, 1, 100, 0);
    drain();
    cfg(50, 20, 6, 7, 1, 1, 1);
    expect_it("R9 count7 ph3 runs", 0, 3, 100, tri_hi(50, 20, 6));
    drain();

    // duty extremes
    cfg(50, 0, 6, 4, 1, 1, 1);
    expect_it("R4 zero duty hs", 0, 0, 100, 0);
    expect_it("R4 zero duty ls", 1, 0, 100, 100);
    drain();
    cfg(50, 4095, 6, 4, 1, 1, 1);
    expect_it("R4 full duty hs", 0, 1, 100, 100);
    expect_it("R4 full duty ls", 1, 1, 100, 0);
    drain();
    cfg(50, 50, 6, 4, 1, 1, 1);
    expect_it("R4 duty equal period hs", 0, 0, 100, 100);
    drain();

    // output enable low
    cfg(50, 20, 6, 4, 1, 1, 0);
    for (int k = 0; k < 4; k++)
      expect_it($sformatf("R10 disabled ph%0d", k), 4, k, 100, 0);
    drain();

    summary();
    $finish;
  end
endmodule